// File: doc/BRIEF.md
# Two-Step-Ahead Signal Predictor

This block supplies the future samples that a deadbeat current loop needs, because such a loop loses two sample periods to computation and to modulation. Once per sample strobe it captures the present grid-side voltage and the present reference-current sample. It then publishes three forecasts. The voltage one and two steps ahead comes from straight-line extrapolation. The reference current two steps ahead is a weighted sum of the present and the four previous reference samples. The weights are fixed values that an outside agent writes through a small register port, and the block never adapts them.

The block remembers the reference forecasts it published on the previous two strobes. When the forecast that was aimed at the present sample misses it by more than a programmable tolerance, the block treats this as an abrupt reference step. For that strobe it publishes the present reference sample unchanged and raises a flag.

A three-state engine sequences each strobe. ST_IDLE waits for a strobe and moves to ST_ACC when one arrives. ST_ACC adds one tap product per clock and moves to ST_FINISH after the last tap. ST_FINISH registers every output and returns to ST_IDLE.

Top module: `signal_predictor`

## Requirements
- R1: A strobe (`smp_stb` high at a rising edge while the engine is in ST_IDLE) captures `v_in` and `r_in`. All outputs change only on the sixth rising edge after the capturing edge and hold their values at every other edge.
- R2: A strobe seen on any of the six edges after a capturing edge is ignored. It changes neither the sample history nor the outputs.
- R3: After reset, `pred_valid` is 0 and `v_next1`, `v_next2`, `r_next2` and `jump_flag` are 0. The first four captured strobes keep them so. From the fifth captured strobe on, `pred_valid` is 1.
- R4: `v_next1` equals 2·v[k] − v[k−1], where v[k] is the latest captured voltage and v[k−1] the one before it.
- R5: `v_next2` equals 3·v[k] − 2·v[k−1].
- R6: Without a jump, `r_next2` equals floor((c0·r[k] + c1·r[k−1] + c2·r[k−2] + c3·r[k−3] + c4·r[k−4]) / 2^FRAC). Coefficient cj is the signed CW-bit value written at address j (0 to 4). The floor applies to negative sums too.
- R7: Address 5 holds the tolerance, taken as the unsigned low DW bits of `cfg_data`. Reset sets all coefficients to 0 and the tolerance to all ones. Writes to addresses 6 and 7 change nothing.
- R8: The jump condition holds when predictions are valid, the forecast published two captured strobes earlier was also valid, and the absolute value of r[k] minus that published forecast is greater than the tolerance. When the condition holds, `r_next2` equals r[k] and `jump_flag` is 1. Otherwise `jump_flag` is 0.
- R9: Any result outside the DW-bit signed range is clamped to −2^(DW−1) or 2^(DW−1)−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe, one clock wide |
| v_in | input | DW | Present voltage sample, signed |
| r_in | input | DW | Present reference-current sample, signed |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address: 0 to 4 coefficients, 5 tolerance |
| cfg_data | input | CW | Configuration write data |
| v_next1 | output | DW | Voltage forecast one step ahead |
| v_next2 | output | DW | Voltage forecast two steps ahead |
| r_next2 | output | DW | Reference forecast two steps ahead |
| pred_valid | output | 1 | Forecasts are valid |
| jump_flag | output | 1 | Abrupt reference step detected on this strobe |

## Verification
A tap history that has shifted wrongly or been disturbed by an ignored strobe appears in `r_next2` and in both voltage forecasts at the next update, six edges after the following strobe. A corrupted forecast memory stays hidden until the tolerance is finite. It then appears two strobes later, as a wrong `jump_flag`, or as `r_next2` holding the raw sample when the weighted sum was due, or the reverse. A faulty fill counter moves the first assertion of `pred_valid` away from the fifth strobe. A reference model in the bench predicts every output on every clock, so a single-edge slip in latency is caught.

// File: rtl/sigpred_pkg.sv
package sigpred_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC,
        ST_FINISH
    } eng_state_t;
endpackage

// File: rtl/sp_coef_bank.sv
module sp_coef_bank #(
    parameter int DW   = 16,
    parameter int CW   = 18,
    parameter int TAPS = 5,
    parameter int AW   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             addr,
    input  logic [CW-1:0]             data,
    output logic [TAPS-1:0][CW-1:0]   coef,
    output logic [DW-1:0]             tol
);
    for (genvar g = 0; g < TAPS; g++) begin : g_coef
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                coef[g] <= '0;
            else if (we && addr == AW'(g))
                coef[g] <= data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tol <= '1;
        else if (we && addr == AW'(TAPS))
            tol <= data[DW-1:0];
    end

    // R7: the tolerance moves only on a write to its own address
    a_r7_tol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == AW'(TAPS)) |=> $stable(tol));
endmodule

// File: rtl/sp_history.sv
module sp_history #(
    parameter int DW   = 16,
    parameter int TAPS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift,
    input  logic signed [DW-1:0]        v_in,
    input  logic signed [DW-1:0]        r_in,
    output logic signed [DW-1:0]        v_now,
    output logic signed [DW-1:0]        v_prev,
    output logic [TAPS-1:0][DW-1:0]     r_taps,
    output logic                        full
);
    localparam int NW = $clog2(TAPS + 1);
    logic [NW-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_now  <= '0;
            v_prev <= '0;
            fill   <= '0;
        end else if (shift) begin
            v_prev <= v_now;
            v_now  <= v_in;
            if (fill != NW'(TAPS))
                fill <= fill + NW'(1);
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_taps[g] <= '0;
            else if (shift) begin
                if (g == 0)
                    r_taps[g] <= r_in;
                else
                    r_taps[g] <= r_taps[(g > 0) ? g - 1 : 0];
            end
        end
    end

    assign full = (fill == NW'(TAPS));

    // R3: the fill count advances only on a captured strobe
    a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(fill));
    // R2: the tap history is frozen between captures
    a_r2_taps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(r_taps));
endmodule

// File: rtl/sp_engine.sv
module sp_engine
    import sigpred_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 18,
    parameter int FRAC = 14,
    parameter int TAPS = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic signed [DW-1:0]        v_now,
    input  logic signed [DW-1:0]        v_prev,
    input  logic [TAPS-1:0][DW-1:0]     r_taps,
    input  logic [TAPS-1:0][CW-1:0]     coef,
    input  logic [DW-1:0]               tol,
    input  logic                        full,
    output logic                        busy,
    output logic signed [DW-1:0]        v_p1,
    output logic signed [DW-1:0]        v_p2,
    output logic signed [DW-1:0]        r_p2,
    output logic                        valid,
    output logic                        jump
);
    localparam int AW = DW + CW + $clog2(TAPS) + 1;
    localparam int IW = (TAPS > 1) ? $clog2(TAPS) : 1;
    localparam longint HI_L = (longint'(1) << (DW - 1)) - 1;
    localparam logic signed [AW-1:0] HI = AW'(HI_L);
    localparam logic signed [AW-1:0] LO = AW'(-HI_L - 1);

    function automatic logic signed [DW-1:0] clip(input logic signed [AW-1:0] x);
        if (x > HI)      return HI[DW-1:0];
        else if (x < LO) return LO[DW-1:0];
        else             return x[DW-1:0];
    endfunction

    eng_state_t state, nxt;
    logic [IW-1:0] idx;
    logic signed [AW-1:0] acc;
    logic signed [DW-1:0] ph1, ph2;
    logic pv1, pv2;

    // tap product for the current index
    logic signed [CW-1:0] c_sel;
    logic signed [DW-1:0] r_sel, r0;
    logic signed [AW-1:0] prod;
    // finish-stage values
    logic signed [AW-1:0] vn, vp, err, mag, tol_ext;
    logic signed [DW-1:0] v1_c, v2_c, r_fc, r_out;
    logic jump_c;

    always_comb begin
        c_sel   = coef[idx];
        r_sel   = r_taps[idx];
        prod    = AW'(c_sel) * AW'(r_sel);
        r0      = r_taps[0];
        vn      = AW'(v_now);
        vp      = AW'(v_prev);
        v1_c    = clip((vn <<< 1) - vp);
        v2_c    = clip((vn <<< 1) + vn - (vp <<< 1));
        r_fc    = clip(acc >>> FRAC);
        err     = AW'(r0) - AW'(ph2);
        mag     = err[AW-1] ? -err : err;
        tol_ext = signed'(AW'({1'b0, tol}));
        jump_c  = full && pv2 && (mag > tol_ext);
        r_out   = jump_c ? r0 : r_fc;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_ACC;
            ST_ACC:    if (idx == IW'(TAPS - 1)) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            acc   <= '0;
            v_p1  <= '0;
            v_p2  <= '0;
            r_p2  <= '0;
            valid <= 1'b0;
            jump  <= 1'b0;
            ph1   <= '0;
            ph2   <= '0;
            pv1   <= 1'b0;
            pv2   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    acc <= '0;
                    idx <= '0;
                end
                ST_ACC: begin
                    acc <= acc + prod;
                    idx <= idx + IW'(1);
                end
                ST_FINISH: begin
                    ph2 <= ph1;
                    pv2 <= pv1;
                    if (full) begin
                        v_p1  <= v1_c;
                        v_p2  <= v2_c;
                        r_p2  <= r_out;
                        valid <= 1'b1;
                        jump  <= jump_c;
                        ph1   <= r_out;
                        pv1   <= 1'b1;
                    end else begin
                        v_p1  <= '0;
                        v_p2  <= '0;
                        r_p2  <= '0;
                        valid <= 1'b0;
                        jump  <= 1'b0;
                        ph1   <= '0;
                        pv1   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: valid forecasts only once the history is full
    a_r3_valid_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> full);
    // R1: outputs move only on the edge that leaves ST_FINISH
    a_r1_quiet_outside_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FINISH) |=> ($stable(v_p1) && $stable(v_p2) && $stable(r_p2) && $stable(valid)));
    // R8: a flagged jump publishes the held present sample
    a_r8_bypass_present: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && jump) |-> (r_p2 == signed'(r_taps[0])));
    // R2: no new computation begins while one is under way
    a_r2_single_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && idx != IW'(TAPS - 1)) |=> (state == ST_ACC));
endmodule

// File: rtl/signal_predictor.sv
module signal_predictor #(
    parameter int DW   = 16,
    parameter int CW   = 18,
    parameter int FRAC = 14,
    parameter int TAPS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] v_in,
    input  logic signed [DW-1:0] r_in,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [CW-1:0]        cfg_data,
    output logic signed [DW-1:0] v_next1,
    output logic signed [DW-1:0] v_next2,
    output logic signed [DW-1:0] r_next2,
    output logic                 pred_valid,
    output logic                 jump_flag
);
    logic busy, take, full;
    logic signed [DW-1:0] v_now, v_prev;
    logic [TAPS-1:0][DW-1:0] r_taps;
    logic [TAPS-1:0][CW-1:0] coef;
    logic [DW-1:0] tol;

    assign take = smp_stb && !busy;

    sp_coef_bank #(.DW(DW), .CW(CW), .TAPS(TAPS), .AW(3)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .data(cfg_data), .coef(coef), .tol(tol)
    );

    sp_history #(.DW(DW), .TAPS(TAPS)) u_hist (
        .clk(clk), .rst_n(rst_n), .shift(take), .v_in(v_in), .r_in(r_in),
        .v_now(v_now), .v_prev(v_prev), .r_taps(r_taps), .full(full)
    );

    sp_engine #(.DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(TAPS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(take), .v_now(v_now), .v_prev(v_prev),
        .r_taps(r_taps), .coef(coef), .tol(tol), .full(full), .busy(busy),
        .v_p1(v_next1), .v_p2(v_next2), .r_p2(r_next2),
        .valid(pred_valid), .jump(jump_flag)
    );
endmodule

// File: tb/tb_signal_predictor.sv
module tb_signal_predictor;
    localparam int DW = 16, CW = 18, FRAC = 14;

    logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0, cfg_we = 1'b0;
    logic signed [DW-1:0] v_in = '0, r_in = '0;
    logic [2:0] cfg_addr = '0;
    logic [CW-1:0] cfg_data = '0;
    logic signed [DW-1:0] v_next1, v_next2, r_next2;
    logic pred_valid, jump_flag;

    signal_predictor #(.DW(DW), .CW(CW), .FRAC(FRAC), .TAPS(5)) dut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .v_in(v_in), .r_in(r_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .v_next1(v_next1), .v_next2(v_next2), .r_next2(r_next2),
        .pred_valid(pred_valid), .jump_flag(jump_flag)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit chk_en = 1'b0;
    string cur_tag = "R3 reset";

    // behavioural reference model
    longint m_coef[8];
    longint m_tol;
    int vq[$], rq[$];
    int m_cnt, pend;
    longint ph1, ph2;
    bit pv1, pv2;
    longint p_v1, p_v2, p_r2, e_v1, e_v2, e_r2;
    bit p_val, p_jmp, e_val, e_jmp;

    function automatic longint sat(input longint x);
        longint hi = (longint'(1) << (DW - 1)) - 1;
        if (x > hi) return hi;
        if (x < -hi - 1) return -hi - 1;
        return x;
    endfunction

    task automatic model_reset();
        foreach (m_coef[i]) m_coef[i] = 0;
        m_tol = (longint'(1) << DW) - 1;
        vq.delete(); rq.delete();
        m_cnt = 0; pend = 0; ph1 = 0; ph2 = 0; pv1 = 0; pv2 = 0;
        e_v1 = 0; e_v2 = 0; e_r2 = 0; e_val = 0; e_jmp = 0;
    endtask

    task automatic model_accept(input int v, input int r);
        longint acc, err;
        vq.push_front(v); rq.push_front(r);
        if (vq.size() > 2) void'(vq.pop_back());
        if (rq.size() > 5) void'(rq.pop_back());
        if (m_cnt < 5) m_cnt++;
        if (m_cnt == 5) begin
            p_v1 = sat(2 * longint'(vq[0]) - vq[1]);
            p_v2 = sat(3 * longint'(vq[0]) - 2 * longint'(vq[1]));
            acc = 0;
            for (int j = 0; j < 5; j++) acc += m_coef[j] * rq[j];
            err = longint'(rq[0]) - ph2;
            if (err < 0) err = -err;
            p_jmp = pv2 && (err > m_tol);
            p_r2 = p_jmp ? longint'(rq[0]) : sat(acc >>> FRAC);
            p_val = 1;
            ph2 = ph1; ph1 = p_r2; pv2 = pv1; pv1 = 1;
        end else begin
            p_v1 = 0; p_v2 = 0; p_r2 = 0; p_val = 0; p_jmp = 0;
            ph2 = ph1; ph1 = 0; pv2 = pv1; pv1 = 0;
        end
    endtask

    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) model_reset();
        else begin
            was_busy = (pend != 0);
            if (pend != 0) begin
                pend--;
                if (pend == 0) begin
                    e_v1 = p_v1; e_v2 = p_v2; e_r2 = p_r2; e_val = p_val; e_jmp = p_jmp;
                end
            end
            if (cfg_we) begin
                if (cfg_addr < 5) m_coef[cfg_addr] = longint'($signed(cfg_data));
                else if (cfg_addr == 5) m_tol = longint'(cfg_data[DW-1:0]);
            end
            if (smp_stb && !was_busy) begin
                model_accept(int'(v_in), int'(r_in));
                pend = 6; // R1: update six edges after capture
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (phase %s): actual %0d expected %0d", req, cur_tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en) begin
            chk("R3 valid", longint'(pred_valid), longint'(e_val));
            chk("R4 v_next1", longint'(v_next1), e_v1);
            chk("R5 v_next2", longint'(v_next2), e_v2);
            chk("R6 r_next2", longint'(r_next2), e_r2);
            chk("R8 jump", longint'(jump_flag), longint'(e_jmp));
        end
    end

    task automatic strobe(input int v, input int r, input int gap);
        @(negedge clk); v_in = DW'(v); r_in = DW'(r); smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic cfg(input int a, input int d);
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 3'(a); cfg_data = CW'(d);
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk); chk_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // extrapolating weights: 3*r[k] - 2*r[k-1] in Q14
        cfg(0, 49152); cfg(1, -32768);
        cur_tag = "R1 R3 R4 R5 R6 ramp";
        for (int k = 0; k < 10; k++) strobe(1000 * k - 3000 + ((k % 2) * 77), 200 * k + 7, 8);

        cur_tag = "R8 jump";
        cfg(5, 50);
        strobe(500, 2007, 8); strobe(520, 2207, 8);
        strobe(540, 2437, 8);           // small miss within tolerance
        strobe(560, 7600, 8);           // abrupt step
        strobe(580, 7800, 8); strobe(600, 8000, 8); strobe(620, 8200, 8);
        strobe(640, 3000, 8);           // step down

        cur_tag = "R2 busy";
        strobe(700, 3100, 2);
        strobe(-9999, -9999, 10);       // arrives while computing
        strobe(710, 3200, 1);
        strobe(12345, 1234, 12);        // arrives while computing

        cur_tag = "R9 saturation";
        cfg(5, 65535);
        strobe(30000, 30000, 8); strobe(30000, 30000, 8);
        strobe(-30000, -30000, 8); strobe(-32768, -32768, 8);
        strobe(32767, 32767, 8);

        cur_tag = "R7 config";
        cfg(6, 12345); cfg(7, -1);
        cfg(0, 8192); cfg(1, 8192); cfg(2, -4096); cfg(3, 4096); cfg(4, 8192);
        for (int k = 0; k < 6; k++) strobe(100 - 40 * k, (k % 2 == 0) ? 1500 : -1300, 8);

        cur_tag = "R6 negative floor";
        cfg(0, 5461); cfg(1, 0); cfg(2, 0); cfg(3, 0); cfg(4, 0);
        for (int k = 0; k < 5; k++) strobe(-7 * k, -3 - 5 * k, 8);
        cfg(5, 0);
        cur_tag = "R8 zero tolerance";
        for (int k = 0; k < 4; k++) strobe(k, 11 * k, 8);

        repeat (10) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule